// File: doc/BRIEF.md
# Accumulator ALU with Selective Flag Update

This block is the arithmetic core of a microprogrammed datapath. It holds one accumulator register and four condition flags: zero, negative, carry and signed overflow. On each clock edge where the enable is high, the block applies the selected operation. The operation combines the accumulator with the operand on the shared bus, or acts on the accumulator alone, and writes the result back into the accumulator.

Each operation class writes a fixed subset of the flags. Every other flag keeps its old value, so microcode can test the outcome of an earlier addition after a shift or a mask. Flags are always derived from the new accumulator value. Results and flags appear at the outputs one clock after the edge that samples the enable.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released, the accumulator reads 0 and all four flags read 0.
- R2: When `en` is low, or `op` carries an unused code (10 to 15), the accumulator and all four flags keep their values across the clock edge.
- R3: Op code 0 (clear) loads 0 into the accumulator, sets Z to 1 and N to 0, and leaves C and V unchanged.
- R4: Op code 1 (add) loads the accumulator plus the bus value, modulo 2^WIDTH. C is the carry out of the sum. V is 1 when both addends have the same sign and the sum's sign differs from it.
- R5: Op code 2 (subtract) loads the accumulator minus the bus value. C is the carry out of accumulator + ~bus + 1, so C = 1 means no borrow. V is signed overflow of that same sum.
- R6: Op codes 3 (bitwise AND) and 4 (bitwise OR) combine the accumulator with the bus value. They update Z and N only and leave C and V unchanged.
- R7: Op code 5 (logical shift left by one) moves the old most significant bit into C and fills bit 0 with 0.
- R8: Op code 6 (logical shift right by one) moves the old bit 0 into C and fills the most significant bit with 0.
- R9: Op code 7 (arithmetic shift right by one) keeps the most significant bit and moves the old bit 0 into C.
- R10: Op code 8 (rotate by one, left by default) feeds the old most significant bit into bit 0 and into C.
- R11: The four shift and rotate codes (5 to 8) update Z, N and C, and leave V unchanged.
- R12: Op code 9 (move inverse) loads the bitwise complement of the bus value and changes no flag.
- R13: Every operation that updates Z and N sets Z to 1 exactly when the new accumulator is 0, and sets N to the new accumulator's most significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Apply the selected operation on this edge |
| op | input | 4 | Operation code |
| bus_opd | input | WIDTH | Operand from the shared bus |
| acc | output | WIDTH | Accumulator value |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry / no-borrow / shifted-out bit |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The assertions assume that `op` and `bus_opd` are stable and known at each rising edge where `en` is high. They also assume that reset is held for at least one edge before any operation is issued. The bench meets both assumptions by changing inputs only on falling edges and by keeping `en` low during and just after reset. The vector table runs as one dependent chain, so each row starts from the accumulator and flags that the previous row left behind. This lets the bench check flag retention across operation classes, for example V surviving a shift and a mask.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [3:0] {
      OP_CLR = 4'd0,
      OP_ADD = 4'd1,
      OP_SUB = 4'd2,
      OP_AND = 4'd3,
      OP_OR  = 4'd4,
      OP_LSL = 4'd5,
      OP_LSR = 4'd6,
      OP_ASR = 4'd7,
      OP_ROT = 4'd8,
      OP_NOT = 4'd9
   } op_e;

   typedef struct packed {
      logic z;
      logic n;
      logic c;
      logic v;
   } flag_t;

   // which flags an operation class writes
   function automatic flag_t upd_mask(input logic [3:0] code);
      flag_t m;
      m = '0;
      case (code)
         OP_CLR, OP_AND, OP_OR:          begin m.z = 1'b1; m.n = 1'b1; end
         OP_ADD, OP_SUB:                 m = '1;
         OP_LSL, OP_LSR, OP_ASR, OP_ROT: begin m.z = 1'b1; m.n = 1'b1; m.c = 1'b1; end
         default:                        m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   full;

   always_comb begin
      b_eff = sub ? ~b : b;
      full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
      sum   = full[MSB:0];
      cout  = full[WIDTH];
      ovf   = (a[MSB] == b_eff[MSB]) && (full[MSB] != a[MSB]);
   end

   always_comb begin
      assert (full[MSB:0] == (sub ? a - b : a + b))
         else $error("assert_diff_R5: adder result mismatch");
   end

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
   import acc_alu_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter bit ROT_LEFT = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [3:0]       code,
   output logic [WIDTH-1:0] res,
   output logic             cout
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] rot_res;
   logic             rot_c;

   generate
      if (ROT_LEFT) begin : g_rot_left
         assign rot_res = {a[MSB-1:0], a[MSB]};
         assign rot_c   = a[MSB];
      end else begin : g_rot_right
         assign rot_res = {a[0], a[MSB:1]};
         assign rot_c   = a[0];
      end
   endgenerate

   always_comb begin
      res  = a;
      cout = 1'b0;
      case (code)
         OP_LSL:  begin res = {a[MSB-1:0], 1'b0};  cout = a[MSB]; end
         OP_LSR:  begin res = {1'b0, a[MSB:1]};    cout = a[0];   end
         OP_ASR:  begin res = {a[MSB], a[MSB:1]};  cout = a[0];   end
         OP_ROT:  begin res = rot_res;             cout = rot_c;  end
         default: begin res = a;                   cout = 1'b0;   end
      endcase
   end

   always_comb begin
      if (code == OP_ASR)
         assert (res[MSB] == a[MSB]) else $error("assert_asr_sign_R9: sign lost");
   end

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
   import acc_alu_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  we,
   input  flag_t upd,
   input  flag_t nxt,
   output flag_t cur
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur <= '0;
      end else if (we) begin
         if (upd.z) cur.z <= nxt.z;
         if (upd.n) cur.n <= nxt.n;
         if (upd.c) cur.c <= nxt.c;
         if (upd.v) cur.v <= nxt.v;
      end
   end

   assert_mask_v_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !upd.v) |=> $stable(cur.v));

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter bit ROT_LEFT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] bus_opd,
   output logic [WIDTH-1:0] acc,
   output logic             flag_z,
   output logic             flag_n,
   output logic             flag_c,
   output logic             flag_v
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("acc_alu: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] as_sum, sh_res, nxt_acc;
   logic             as_c, as_v, sh_c;
   logic             acc_we;
   flag_t            upd, nxt_f, cur_f;

   acc_alu_addsub #(.WIDTH(WIDTH)) i_addsub (
      .a(acc), .b(bus_opd), .sub(op == OP_SUB),
      .sum(as_sum), .cout(as_c), .ovf(as_v)
   );

   acc_alu_shift #(.WIDTH(WIDTH), .ROT_LEFT(ROT_LEFT)) i_shift (
      .a(acc), .code(op), .res(sh_res), .cout(sh_c)
   );

   always_comb begin
      acc_we  = 1'b1;
      nxt_acc = acc;
      case (op)
         OP_CLR:                         nxt_acc = '0;
         OP_ADD, OP_SUB:                 nxt_acc = as_sum;
         OP_AND:                         nxt_acc = acc & bus_opd;
         OP_OR:                          nxt_acc = acc | bus_opd;
         OP_LSL, OP_LSR, OP_ASR, OP_ROT: nxt_acc = sh_res;
         OP_NOT:                         nxt_acc = ~bus_opd;
         default:                        acc_we  = 1'b0;
      endcase
      upd     = upd_mask(op);
      nxt_f.z = (nxt_acc == '0);
      nxt_f.n = nxt_acc[MSB];
      nxt_f.c = (op == OP_ADD || op == OP_SUB) ? as_c : sh_c;
      nxt_f.v = as_v;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)             acc <= '0;
      else if (en && acc_we)  acc <= nxt_acc;
   end

   acc_alu_flags i_flags (
      .clk(clk), .rst_n(rst_n), .we(en), .upd(upd), .nxt(nxt_f), .cur(cur_f)
   );

   assign flag_z = cur_f.z;
   assign flag_n = cur_f.n;
   assign flag_c = cur_f.c;
   assign flag_v = cur_f.v;

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en || op > 4'd9) |=> ($stable(acc) && $stable({flag_z, flag_n, flag_c, flag_v})));

   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op == OP_CLR) |=> (acc == '0 && flag_z && !flag_n && $stable({flag_c, flag_v})));

   assert_logic_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (op == OP_AND || op == OP_OR)) |=> $stable({flag_c, flag_v}));

   assert_lsr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op == OP_LSR) |=> (!acc[MSB] && flag_c == $past(acc[0])));

   assert_shift_v_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op >= OP_LSL && op <= OP_ROT) |=> $stable(flag_v));

   assert_not_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op == OP_NOT) |=> (acc == ~$past(bus_opd) && $stable({flag_z, flag_n, flag_c, flag_v})));

   assert_zn_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op <= OP_ROT) |=> (flag_z == (acc == '0) && flag_n == acc[MSB]));

endmodule

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;
   localparam int W = 16;
   localparam int NV = 20;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0;
   logic [3:0]   op = 4'd0;
   logic [W-1:0] bus_opd = '0;
   logic [W-1:0] acc;
   logic         flag_z, flag_n, flag_c, flag_v;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   acc_alu i_acc_alu (
      .clk(clk), .rst_n(rst_n), .en(en), .op(op), .bus_opd(bus_opd),
      .acc(acc), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v)
   );

   // {op, bus, expected acc, expected {Z,N,C,V}}; rows form one dependent chain
   localparam logic [39:0] VEC [NV] = '{
      {4'd9, 16'h0000, 16'hFFFF, 4'b0000},  // R12 move inverse
      {4'd1, 16'h0001, 16'h0000, 4'b1010},  // R4 carry, wrap to zero
      {4'd9, 16'h8000, 16'h7FFF, 4'b1010},  // R12 flags kept
      {4'd1, 16'h0001, 16'h8000, 4'b0101},  // R4 signed overflow
      {4'd3, 16'h00FF, 16'h0000, 4'b1001},  // R6 AND keeps C,V
      {4'd4, 16'h8001, 16'h8001, 4'b0101},  // R6 OR
      {4'd5, 16'h0000, 16'h0002, 4'b0011},  // R7 LSL, R11 V kept
      {4'd2, 16'h0003, 16'hFFFF, 4'b0100},  // R5 borrow -> C=0
      {4'd7, 16'h0000, 16'hFFFF, 4'b0110},  // R9 ASR keeps sign
      {4'd6, 16'h0000, 16'h7FFF, 4'b0010},  // R8 LSR
      {4'd8, 16'h0000, 16'hFFFE, 4'b0100},  // R10 rotate
      {4'd2, 16'h7FFF, 16'h7FFF, 4'b0011},  // R5 overflow, no borrow
      {4'd0, 16'h1234, 16'h0000, 4'b1011},  // R3 clear keeps C,V
      {4'd1, 16'h0005, 16'h0005, 4'b0000},  // R4 plain add
      {4'd2, 16'h0005, 16'h0000, 4'b1010},  // R5 zero result, R13
      {4'd8, 16'h0000, 16'h0000, 4'b1000},  // R10 rotate of zero
      {4'd9, 16'h5555, 16'hAAAA, 4'b1000},  // R12
      {4'd8, 16'h0000, 16'h5555, 4'b0010},  // R10 msb into bit 0 and C
      {4'd6, 16'h0000, 16'h2AAA, 4'b0010},  // R8
      {4'd12,16'hFFFF, 16'h2AAA, 4'b0010}   // R2 unused code
   };

   task automatic check(input string req, input logic [W+3:0] act, input logic [W+3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic [3:0] o, input logic [W-1:0] b, input logic e);
      @(negedge clk);
      op = o; bus_opd = b; en = e;
      @(negedge clk);
      en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset held", {acc, flag_z, flag_n, flag_c, flag_v}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {acc, flag_z, flag_n, flag_c, flag_v}, '0);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][39:36], VEC[i][35:20], 1'b1);
         check($sformatf("vector %0d R2-R13 chain", i),
               {acc, flag_z, flag_n, flag_c, flag_v}, {VEC[i][19:4], VEC[i][3:0]});
      end

      // R2: enable low ignores an add
      step(4'd1, 16'h1111, 1'b0);
      check("R2 en low", {acc, flag_z, flag_n, flag_c, flag_v}, {16'h2AAA, 4'b0010});

      // R7: LSL of 0x8000 -> 0, C=1, Z=1 (R13)
      step(4'd9, 16'h7FFF, 1'b1);
      step(4'd5, 16'h0000, 1'b1);
      check("R7 LSL msb out", {acc, flag_z, flag_n, flag_c, flag_v}, {16'h0000, 4'b1010});

      // R9: ASR of 0x8001 -> 0xC000, C=1, N=1
      step(4'd9, 16'h7FFE, 1'b1);
      step(4'd7, 16'h0000, 1'b1);
      check("R9 ASR negative", {acc, flag_z, flag_n, flag_c, flag_v}, {16'hC000, 4'b0110});

      // R5: 0x8000 - 1 -> 0x7FFF, V=1, C=1
      step(4'd9, 16'h7FFF, 1'b1);
      step(4'd2, 16'h0001, 1'b1);
      check("R5 negative overflow", {acc, flag_z, flag_n, flag_c, flag_v}, {16'h7FFF, 4'b0011});

      // R1: reset mid-run clears everything
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-run reset", {acc, flag_z, flag_n, flag_c, flag_v}, '0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule